// File: doc/BRIEF.md
# Quad-Channel Multi-Mode Interval Timer

This block is a four-channel down-counting timer that sits on a simple APB-style register bus. Each channel has one 32-bit reload register and one 32-bit counter register. A per-channel mode field reuses that single pair as one 32-bit timer, as two 16-bit timers, as four 8-bit timers, or as a PWM generator. Every channel picks its count tick from one of two sources: the bus clock itself, or its own external tick pin. The external pin is synchronised and edge-detected inside the block. All logic runs on the bus clock.

Each channel owns a 4-bit field, at bits 4c+3..4c, in three registers: channel enable, interrupt enable and interrupt status. Bit i of that field belongs to sub-timer i. When a sub-timer underflows, it reloads, keeps counting and raises its status bit. Software clears status bits by writing ones. The single interrupt output is active while any status bit is set and its matching enable bit is also set.

Top module: `pit_quad`

## Requirements
- R1: After reset, the register at address 0x00 reads the ID_VALUE parameter (default 0x50490100), the register at 0x10 reads 0x00000404 (bits 7:0 hold the channel count, bits 15:8 hold the sub-timers per channel), every other register reads zero, irq is low and all PWM outputs are low.
- R2: Fixed register addresses: interrupt enable at 0x14, interrupt status at 0x18, channel enable at 0x1C. For channel n, control is at 0x20+0x10·n, reload at 0x24+0x10·n and counter at 0x28+0x10·n. In the enable, interrupt-enable and status registers, bit 4c+i belongs to sub-timer i of channel c.
- R3: Control bits 2:0 = 1 selects one 32-bit timer, enabled by field bit 0. On each tick it steps from a count v to v-1. At count 0 it loads the reload value instead, so one period is reload+1 ticks.
- R4: Control bits 2:0 = 2 selects two 16-bit timers. Sub-timer 0 uses bits 15:0 and sub-timer 1 uses bits 31:16 of both reload and counter. Each half counts and reloads on its own, only while its own enable bit is set.
- R5: Control bits 2:0 = 3 selects four 8-bit timers. Sub-timer i uses byte i (bits 8i+7..8i) of reload and counter. Each byte counts and reloads on its own, under enable bit i.
- R6: Control bits 2:0 = 4 selects PWM, enabled by field bit 0. The output stays high for reload[31:16]+1 ticks and low for reload[15:0]+1 ticks. Status bit 0 of the channel sets each time a high phase ends.
- R7: A channel's PWM output is low whenever its mode is not PWM, and goes low within two cycles after its field bit 0 is cleared.
- R8: Control bit 3 = 1 makes the bus clock the tick source. Control bit 3 = 0 makes each rising edge of the channel's external pin one tick, whatever the high time, with a fixed latency of two cycles. With no edge on the pin, no tick occurs.
- R9: Each sub-timer underflow sets the matching status bit one cycle later.
- R10: Writing 1 to a status bit clears it. Writing 0 leaves the bit unchanged.
- R11: A status bit that is set by an underflow in the same cycle as a write-one-to-clear stays set.
- R12: irq is high exactly while some status bit and its matching interrupt-enable bit are both set.
- R13: A write to the counter register loads the count directly and takes priority over counting in that cycle. Reads of the counter return the live count.
- R14: A channel in mode 0, 5, 6 or 7, or a sub-timer whose enable bit is clear, holds its count and raises no status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; all registers use it |
| rst_n | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | Bus select |
| penable | input | 1 | Bus access phase |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 8 | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, combinational from paddr |
| ext_clk | input | 4 | Per-channel external tick pins, asynchronous |
| pwm_out | output | 4 | Per-channel PWM output |
| irq | output | 1 | Combined interrupt |

## Verification
The hardest case to reach from the ports is an underflow that lands in exactly the cycle when software writes a one to clear the same status bit. Bus transfers take several cycles, so lining the two up by timing would be fragile. The bench avoids that by setting a 32-bit channel to a reload value of zero and a count of zero. That channel then underflows on every bus clock, so every clearing write is bound to collide with a new set. A second awkward case is the external tick path: a long high pulse and a short pulse must each count once, and this is checked by reading the counter back after pulse trains of known length.

// File: rtl/pit_pkg.sv
package pit_pkg;
  localparam int SUBS   = 4;
  localparam int CNT_W  = 32;
  localparam int ADDR_W = 8;

  localparam logic [2:0] MODE_T32 = 3'd1;
  localparam logic [2:0] MODE_T16 = 3'd2;
  localparam logic [2:0] MODE_T8  = 3'd3;
  localparam logic [2:0] MODE_PWM = 3'd4;

  localparam logic [ADDR_W-1:0] A_ID   = 8'h00;
  localparam logic [ADDR_W-1:0] A_CFG  = 8'h10;
  localparam logic [ADDR_W-1:0] A_IEN  = 8'h14;
  localparam logic [ADDR_W-1:0] A_STS  = 8'h18;
  localparam logic [ADDR_W-1:0] A_CHEN = 8'h1C;

  function automatic logic [ADDR_W-1:0] ctl_addr(input int n);
    return ADDR_W'(32'h20 + n * 16);
  endfunction

  function automatic logic [ADDR_W-1:0] rel_addr(input int n);
    return ADDR_W'(32'h24 + n * 16);
  endfunction

  function automatic logic [ADDR_W-1:0] cnt_addr(input int n);
    return ADDR_W'(32'h28 + n * 16);
  endfunction

  // mask of the low w bits of a counter lane
  function automatic logic [CNT_W-1:0] lane_mask(input int w);
    return (w >= CNT_W) ? '1 : ((CNT_W'(1) << w) - CNT_W'(1));
  endfunction

  // next value of one lane: reload at zero, otherwise step down
  function automatic logic [CNT_W-1:0] lane_next(input logic [CNT_W-1:0] cur,
                                                 input logic [CNT_W-1:0] rld);
    return (cur == '0) ? rld : cur - CNT_W'(1);
  endfunction

  function automatic logic mode_idle(input logic [2:0] m);
    return (m == 3'd0) || (m > MODE_PWM);
  endfunction
endpackage

// File: rtl/pit_ext_sync.sv
module pit_ext_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic tick
);
  logic s1_q, s2_q, s3_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      s3_q <= 1'b0;
    end else begin
      s1_q <= async_in;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign tick = s2_q & ~s3_q;
endmodule

// File: rtl/pit_channel.sv
module pit_channel
  import pit_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       mode,
  input  logic             tick,
  input  logic [SUBS-1:0]  en,
  input  logic [CNT_W-1:0] reload,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] cnt_wdata,
  output logic [CNT_W-1:0] cnt_q,
  output logic [SUBS-1:0]  uf,
  output logic             pwm_q
);
  logic [CNT_W-1:0] cnt_d;
  logic             pwm_d;

  always_comb begin
    int               w;
    int               nl;
    int               sh;
    logic [CNT_W-1:0] mask;
    logic [CNT_W-1:0] cur;
    logic [CNT_W-1:0] nv;
    cnt_d = cnt_q;
    pwm_d = pwm_q;
    uf    = '0;
    w     = CNT_W;
    nl    = 0;
    case (mode)
      MODE_T32: begin w = CNT_W;     nl = 1; end
      MODE_T16: begin w = CNT_W / 2; nl = 2; end
      MODE_T8:  begin w = CNT_W / 4; nl = 4; end
      default:  begin w = CNT_W;     nl = 0; end
    endcase
    mask = lane_mask(w);
    for (int i = 0; i < SUBS; i++) begin
      sh  = i * w;
      cur = (cnt_q >> sh) & mask;
      nv  = lane_next(cur, (reload >> sh) & mask) & mask;
      if (i < nl && en[i] && tick) begin
        cnt_d = (cnt_d & ~(mask << sh)) | (nv << sh);
        uf[i] = (cur == '0);
      end
    end
    if (mode == MODE_PWM) begin
      if (!en[0]) begin
        pwm_d = 1'b0;
      end else if (tick) begin
        if (cnt_q[15:0] == 16'd0) begin
          pwm_d = ~pwm_q;
          cnt_d = {16'd0, (pwm_q ? reload[15:0] : reload[31:16])};
          uf[0] = pwm_q;
        end else begin
          cnt_d = {cnt_q[31:16], cnt_q[15:0] - 16'd1};
        end
      end
    end else begin
      pwm_d = 1'b0;
    end
    if (cnt_wr) cnt_d = cnt_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      pwm_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      pwm_q <= pwm_d;
    end
  end
endmodule

// File: rtl/pit_quad.sv
module pit_quad
  import pit_pkg::*;
#(
  parameter int          NCH      = 4,
  parameter logic [31:0] ID_VALUE = 32'h5049_0100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [CNT_W-1:0]  pwdata,
  output logic [CNT_W-1:0]  prdata,
  input  logic [NCH-1:0]    ext_clk,
  output logic [NCH-1:0]    pwm_out,
  output logic              irq
);
  localparam int FW = NCH * SUBS;
  localparam logic [CNT_W-1:0] CFG_VALUE = {16'd0, 8'(SUBS), 8'(NCH)};

  logic                      wr_en;
  logic                      ien_wr;
  logic [FW-1:0]             ien_q, ists_q, chen_q, uf_set, clr_mask;
  logic [NCH-1:0][3:0]       ctrl_q;
  logic [NCH-1:0][2:0]       mode;
  logic [NCH-1:0][CNT_W-1:0] rel_q, cnt_q;
  logic [NCH-1:0]            cnt_wr, ext_tick, tick;

  assign wr_en    = psel & penable & pwrite;
  assign ien_wr   = wr_en && (paddr == A_IEN);
  assign clr_mask = (wr_en && (paddr == A_STS)) ? pwdata[FW-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien_q  <= '0;
      chen_q <= '0;
      ists_q <= '0;
    end else begin
      if (ien_wr) ien_q <= pwdata[FW-1:0];
      if (wr_en && paddr == A_CHEN) chen_q <= pwdata[FW-1:0];
      ists_q <= (ists_q & ~clr_mask) | uf_set;
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ctrl_q[g] <= '0;
        rel_q[g]  <= '0;
      end else begin
        if (wr_en && paddr == ctl_addr(g)) ctrl_q[g] <= pwdata[3:0];
        if (wr_en && paddr == rel_addr(g)) rel_q[g]  <= pwdata;
      end
    end

    assign mode[g]   = ctrl_q[g][2:0];
    assign cnt_wr[g] = wr_en && (paddr == cnt_addr(g));
    assign tick[g]   = ctrl_q[g][3] | ext_tick[g];

    pit_ext_sync u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (ext_clk[g]),
      .tick     (ext_tick[g])
    );

    pit_channel u_chan (
      .clk       (clk),
      .rst_n     (rst_n),
      .mode      (mode[g]),
      .tick      (tick[g]),
      .en        (chen_q[g*SUBS +: SUBS]),
      .reload    (rel_q[g]),
      .cnt_wr    (cnt_wr[g]),
      .cnt_wdata (pwdata),
      .cnt_q     (cnt_q[g]),
      .uf        (uf_set[g*SUBS +: SUBS]),
      .pwm_q     (pwm_out[g])
    );
  end

  assign irq = |(ists_q & ien_q);

  always_comb begin
    prdata = '0;
    case (paddr)
      A_ID:    prdata = ID_VALUE;
      A_CFG:   prdata = CFG_VALUE;
      A_IEN:   prdata[FW-1:0] = ien_q;
      A_STS:   prdata[FW-1:0] = ists_q;
      A_CHEN:  prdata[FW-1:0] = chen_q;
      default: ;
    endcase
    for (int n = 0; n < NCH; n++) begin
      if (paddr == ctl_addr(n)) prdata = {28'd0, ctrl_q[n]};
      if (paddr == rel_addr(n)) prdata = rel_q[n];
      if (paddr == cnt_addr(n)) prdata = cnt_q[n];
    end
  end
endmodule

// File: rtl/pit_quad_chk.sv
module pit_quad_chk
  import pit_pkg::*;
#(
  parameter int NCH = 4
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [NCH*SUBS-1:0]       ists,
  input logic [NCH*SUBS-1:0]       ien,
  input logic [NCH*SUBS-1:0]       clr,
  input logic [NCH*SUBS-1:0]       uf_set,
  input logic                      ien_wr,
  input logic                      irq,
  input logic [NCH-1:0]            ext_tick,
  input logic [NCH-1:0][2:0]       mode,
  input logic [NCH-1:0][CNT_W-1:0] cnt,
  input logic [NCH-1:0]            cnt_wr,
  input logic [NCH-1:0]            pwm
);
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (|uf_set) |=> ((ists & $past(uf_set)) == $past(uf_set))); // R11

  AST_W1C_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (|ists) |=> ((ists & $past(ists & ~clr)) == $past(ists & ~clr))); // R10

  AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    ((|(uf_set & ien)) && !ien_wr) |=> irq); // R12

  for (genvar g = 0; g < NCH; g++) begin : g_chk
    AST_EXT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      ext_tick[g] |=> !ext_tick[g]); // R8

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_idle(mode[g]) && !cnt_wr[g]) |=> $stable(cnt[g])); // R14

    AST_PWM_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (mode[g] != MODE_PWM) |=> !pwm[g]); // R7
  end
endmodule

bind pit_quad pit_quad_chk #(.NCH(NCH)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ists     (ists_q),
  .ien      (ien_q),
  .clr      (clr_mask),
  .uf_set   (uf_set),
  .ien_wr   (ien_wr),
  .irq      (irq),
  .ext_tick (ext_tick),
  .mode     (mode),
  .cnt      (cnt_q),
  .cnt_wr   (cnt_wr),
  .pwm      (pwm_out)
);

// File: tb/sim_pit_quad.sv
`timescale 1ns/1ps
module sim_pit_quad;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [7:0]  paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic [3:0]  ext_clk = '0;
  logic [3:0]  pwm_out;
  logic        irq;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pit_quad u0 (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .ext_clk(ext_clk), .pwm_out(pwm_out), .irq(irq)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    psel = 1; pwrite = 1; penable = 0; paddr = a; pwdata = d;
    @(negedge clk);
    penable = 1;
    @(negedge clk);
    psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    psel = 1; pwrite = 0; paddr = a;
    #1 d = prdata;
    psel = 0;
  endtask

  function automatic logic [31:0] step(input logic [31:0] c, input logic [31:0] r);
    return (c == 0) ? r : c - 1;
  endfunction

  task automatic t_reset;
    logic [31:0] v;
    rd(8'h00, v); check(v == 32'h5049_0100, "R1 id", v, 32'h5049_0100);
    rd(8'h10, v); check(v == 32'h0000_0404, "R1 cfg", v, 32'h0000_0404);
    rd(8'h14, v); check(v == 0, "R1 ien", v, 0);
    rd(8'h18, v); check(v == 0, "R1 sts", v, 0);
    rd(8'h1C, v); check(v == 0, "R1 chen", v, 0);
    rd(8'h50, v); check(v == 0, "R1 ctl3", v, 0);
    check(irq == 0, "R1 irq", irq, 0);
    check(pwm_out == 0, "R1 pwm", pwm_out, 0);
  endtask

  task automatic t_t32;
    logic [31:0] v, prev;
    wr(8'h20, 32'h9); wr(8'h24, 32'd3); wr(8'h28, 32'd7);
    wr(8'h14, 32'h1); wr(8'h1C, 32'h1);
    @(negedge clk); psel = 1; pwrite = 0; paddr = 8'h28; #1 prev = prdata;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk); #1 v = prdata;
      check(v == step(prev, 3), "R3 count/reload", v, step(prev, 3));
      prev = v;
    end
    psel = 0;
    rd(8'h18, v); check(v[0] == 1'b1, "R9 sts bit0", v, 32'h1);
    check(irq == 1'b1, "R12 irq on", irq, 1);
    wr(8'h28, 32'd500);
    rd(8'h28, v); check(v == 32'd499, "R13 preload live", v, 499);
    check(pwm_out[0] == 1'b0, "R7 non-pwm low", pwm_out, 0);
    wr(8'h1C, 32'h0);
    rd(8'h28, prev);
    repeat (10) @(negedge clk);
    rd(8'h28, v); check(v == prev, "R14 disabled hold", v, prev);
  endtask

  task automatic t_w1c;
    logic [31:0] v;
    wr(8'h18, 32'h0);
    rd(8'h18, v); check(v[0] == 1'b1, "R10 write 0 keeps", v, 1);
    wr(8'h18, 32'h1);
    rd(8'h18, v); check(v == 0, "R10 write 1 clears", v, 0);
    check(irq == 0, "R12 irq off", irq, 0);
  endtask

  task automatic t_race;
    logic [31:0] v;
    wr(8'h24, 32'd0); wr(8'h28, 32'd0); wr(8'h1C, 32'h1);
    wr(8'h18, 32'h1);
    rd(8'h18, v); check(v[0] == 1'b1, "R11 set wins", v, 1);
    wr(8'h14, 32'h0);
    check(irq == 0, "R12 masked", irq, 0);
    wr(8'h14, 32'h1);
    check(irq == 1, "R12 unmasked", irq, 1);
    wr(8'h1C, 32'h0);
    wr(8'h18, 32'hFFFF);
    rd(8'h18, v); check(v == 0, "R10 clear after stop", v, 0);
  endtask

  task automatic t_t16;
    logic [31:0] v, prev;
    wr(8'h30, 32'hA); wr(8'h34, {16'd2, 16'd4}); wr(8'h38, {16'd9, 16'd6});
    wr(8'h1C, 32'h10);
    @(negedge clk); psel = 1; paddr = 8'h38; #1 prev = prdata;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk); #1 v = prdata;
      check(v[15:0] == step({16'd0, prev[15:0]}, 4), "R4 low half", v, prev);
      check(v[31:16] == 16'd9, "R4 high half held", v, 32'd9);
      prev = v;
    end
    psel = 0;
    rd(8'h18, v); check((v & 32'h30) == 32'h10, "R4 sts sub0 only", v, 32'h10);
    wr(8'h1C, 32'h30);
    @(negedge clk); psel = 1; paddr = 8'h38; #1 prev = prdata;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk); #1 v = prdata;
      check(v[15:0] == step({16'd0, prev[15:0]}, 4), "R4 low half both", v, prev);
      check(v[31:16] == step({16'd0, prev[31:16]}, 2), "R4 high half both", v, prev);
      prev = v;
    end
    psel = 0;
    rd(8'h18, v); check((v & 32'h30) == 32'h30, "R4 sts both", v, 32'h30);
    wr(8'h1C, 32'h0); wr(8'h18, 32'hFFFF);
  endtask

  task automatic t_t8;
    logic [31:0] v, prev;
    logic [31:0] rl;
    rl = 32'h0403_0201;
    wr(8'h40, 32'hB); wr(8'h44, rl); wr(8'h48, 32'h0);
    wr(8'h1C, 32'hF00);
    @(negedge clk); psel = 1; paddr = 8'h48; #1 prev = prdata;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk); #1 v = prdata;
      for (int b = 0; b < 4; b++)
        check(v[8*b +: 8] == 8'(step({24'd0, prev[8*b +: 8]}, {24'd0, rl[8*b +: 8]})),
              "R5 byte lane", v, prev);
      prev = v;
    end
    psel = 0;
    rd(8'h18, v); check((v & 32'hF00) == 32'hF00, "R5 sts lanes", v, 32'hF00);
    wr(8'h1C, 32'h0); wr(8'h18, 32'hFFFF);
  endtask

  task automatic t_pwm;
    logic [31:0] v;
    logic cur, last;
    int run;
    bit first;
    int nhi, nlo;
    wr(8'h50, 32'hC); wr(8'h54, {16'd1, 16'd2}); wr(8'h58, 32'h0);
    wr(8'h1C, 32'h1000);
    run = 1; first = 1; nhi = 0; nlo = 0; last = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk); #1 cur = pwm_out[3];
      if (i == 0) last = cur;
      else if (cur == last) run++;
      else begin
        if (!first) begin
          check(run == (last ? 2 : 3), last ? "R6 high length" : "R6 low length",
                run, last ? 2 : 3);
          if (last) nhi++; else nlo++;
        end
        first = 0; run = 1; last = cur;
      end
    end
    check(nhi > 3 && nlo > 3, "R6 phase count", nhi, 4);
    rd(8'h18, v); check(v[12] == 1'b1, "R6 sts on high end", v, 32'h1000);
    wr(8'h1C, 32'h0);
    @(negedge clk);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk); #1 check(pwm_out[3] == 0, "R7 disabled low", pwm_out, 0);
    end
    wr(8'h18, 32'hFFFF);
  endtask

  task automatic t_ext;
    logic [31:0] v;
    wr(8'h20, 32'h1); wr(8'h24, 32'hFFFF); wr(8'h28, 32'd100); wr(8'h1C, 32'h1);
    repeat (10) @(negedge clk);
    rd(8'h28, v); check(v == 100, "R8 no edge no tick", v, 100);
    for (int p = 0; p < 5; p++) begin
      @(negedge clk); ext_clk[0] = 1;
      repeat (3) @(negedge clk);
      ext_clk[0] = 0;
      repeat (2) @(negedge clk);
    end
    repeat (5) @(negedge clk);
    rd(8'h28, v); check(v == 95, "R8 five edges", v, 95);
    @(negedge clk); ext_clk[0] = 1;
    repeat (20) @(negedge clk);
    ext_clk[0] = 0;
    repeat (5) @(negedge clk);
    rd(8'h28, v); check(v == 94, "R8 long pulse one tick", v, 94);
  endtask

  task automatic t_idle;
    logic [31:0] v;
    wr(8'h1C, 32'h0); wr(8'h18, 32'hFFFF);
    wr(8'h20, 32'hD); wr(8'h28, 32'd50); wr(8'h1C, 32'hF);
    repeat (10) @(negedge clk);
    rd(8'h28, v); check(v == 50, "R14 mode 5 hold", v, 50);
    wr(8'h20, 32'h8);
    repeat (10) @(negedge clk);
    rd(8'h28, v); check(v == 50, "R14 mode 0 hold", v, 50);
    rd(8'h18, v); check(v == 0, "R14 no status", v, 0);
    rd(8'h24, v); check(v == 32'hFFFF, "R2 reload readback", v, 32'hFFFF);
    wr(8'h1C, 32'h0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_t32();
    t_w1c();
    t_race();
    t_t16();
    t_t8();
    t_pwm();
    t_ext();
    t_idle();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule